// File: doc/BRIEF.md
# EEPROM Shadow Cache with Checksum Validation

This block sits between consumers of configuration data and a word-level read/write port of a 64-word by 16-bit serial EEPROM. It holds a register copy of the whole device and serves indexed word lookups from that copy. The copy is filled lazily. When a lookup arrives while the copy is marked invalid, the block reads every word in ascending address order and keeps a running 16-bit sum. The copy counts as valid only when the wrapped sum of all 64 words equals 0xBABA and a signature field in word 0 carries the valid code.

Validity is held only in the signature field of the copied word 0. Any write, a failed checksum and a checksum update all clear that field, so the next lookup refills the copy. The checksum-update operation reads words 0 to 62 from the device and writes 0xBABA minus their sum into word 63. A single operation port carries lookups, writes and checksum updates. While the block works through a refill, a write or an update, `busy_o` stays high and a presented operation waits.

Top module: `ee_shadow_cache`

## Requirements
- R1: After reset `busy_o`, `done_o`, `ok_o` and `mem_req_o` are low, `rdata_o` is zero, and the copy is invalid.
- R2: A refill issues one read at a time for addresses 0 to 63, in ascending order. Each request stays asserted with a stable address until `mem_ack_i`, which also carries `mem_rdata_i`.
- R3: When the copy is valid, a lookup with an index below 64 sets `done_o` and `ok_o` one cycle after acceptance, returns the copied word and makes no device access.
- R4: A refill whose wrapped 16-bit sum of words 0..63 differs from 0xBABA clears the copied signature. The lookup then completes with `ok_o`=0 and `rdata_o`=0, and the next lookup refills again.
- R5: The signature field is bits 15:14 of word 0 and the valid code is 2'b01. A refill with a correct sum but another code in that field fails like R4.
- R6: A lookup with an index of 64 or more completes one cycle after acceptance with `ok_o`=0 and `rdata_o`=0. It makes no device access and starts no refill, whatever the state of the copy.
- R7: A write with an index below 64 issues one device write of `wdata_i` to that address and completes with `ok_o`=1. It invalidates the copy, so the next lookup refills and returns the new contents.
- R8: A checksum update reads words 0 to 62 in ascending order, then writes 0xBABA minus their wrapped sum to word 63. It completes with `ok_o`=1, returns the written value on `rdata_o` and invalidates the copy.
- R9: `busy_o` is high from the cycle after a refill, write or update is accepted until that operation completes. An operation is accepted only in a cycle where `busy_o` is low.
- R10: `op_i` encodes 2'b00 lookup, 2'b01 write and 2'b10 checksum update. The code 2'b11, and a write with an index of 64 or more, complete one cycle after acceptance with `ok_o`=0 and no device access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operation presented; taken when `busy_o` is low |
| op_i | input | 2 | Operation code (R10) |
| idx_i | input | 7 | Word index for lookup or write |
| wdata_i | input | 16 | Write data |
| busy_o | output | 1 | Refill, write or checksum update in progress |
| done_o | output | 1 | One-cycle completion strobe |
| ok_o | output | 1 | Completion status, valid with `done_o` |
| rdata_o | output | 16 | Lookup word or written checksum, valid with `done_o` |
| mem_req_o | output | 1 | Device word access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 6 | Device word address |
| mem_wdata_o | output | 16 | Device write data |
| mem_ack_i | input | 1 | Device access complete |
| mem_rdata_i | input | 16 | Device read data, valid with `mem_ack_i` |

## Verification
The assertions check on every cycle that a device request holds steady until acknowledged and that refill addresses step by one. They also check that out-of-range and hit lookups complete in one cycle without device traffic, that a failing completion returns zero, and that a device write or a signature clear leaves the copy invalid on the next cycle. Only the bench scenarios can show the data-level results, because these depend on memory contents. These results are the word returned after a refill, that a bad sum or bad signature fails and forces another refill, the exact checksum value written back, and that a hit returns the copy even after the device changed behind it.

// File: rtl/ee_shadow_pkg.sv
package ee_shadow_pkg;
  typedef enum logic [1:0] {
    OP_LOOKUP = 2'b00,
    OP_WRITE  = 2'b01,
    OP_CSUM   = 2'b10,
    OP_RSVD   = 2'b11
  } ee_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_RESP,
    ST_WR,
    ST_CS_RD,
    ST_CS_WR
  } ee_state_e;
endpackage

// File: rtl/ee_shadow_store.sv
module ee_shadow_store #(
  parameter int WORDS  = 64,
  parameter int DW     = 16,
  parameter int AW     = $clog2(WORDS),
  parameter int SIG_HI = 15,
  parameter int SIG_LO = 14,
  parameter logic [SIG_HI-SIG_LO:0] SIG_VALID = 2'b01
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          clr_sig_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o,
  output logic          sig_ok_o
);
  localparam logic [DW-1:0] SIG_MASK =
    DW'(((1 << (SIG_HI - SIG_LO + 1)) - 1) << SIG_LO);

  logic [WORDS-1:0][DW-1:0] flat;

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [DW-1:0] q;
    logic          wsel;
    logic [DW-1:0] d;
    assign wsel = we_i && (waddr_i == AW'(g));
    assign d    = wsel ? wdata_i : q;
    if (g == 0) begin : g_sig
      // signature word: clear wins over a same-cycle load
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= clr_sig_i ? (d & ~SIG_MASK) : d;
      end
    end else begin : g_plain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   q <= '0;
        else if (wsel) q <= wdata_i;
      end
    end
    assign flat[g] = q;
  end

  assign rdata_o  = flat[raddr_i];
  assign sig_ok_o = (flat[0][SIG_HI:SIG_LO] == SIG_VALID);

  // R7
  sig_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_sig_i |=> !sig_ok_o);
endmodule

// File: rtl/ee_sum_acc.sv
module ee_sum_acc #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          add_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] sum_o,
  output logic [DW-1:0] sum_nxt_o
);
  assign sum_nxt_o = sum_o + din_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sum_o <= '0;
    else if (clr_i) sum_o <= '0;
    else if (add_i) sum_o <= sum_nxt_o;
  end
endmodule

// File: rtl/ee_shadow_ctrl.sv
module ee_shadow_ctrl
  import ee_shadow_pkg::*;
#(
  parameter int WORDS = 64,
  parameter int DW    = 16,
  parameter int AW    = $clog2(WORDS),
  parameter logic [DW-1:0] SUM_TARGET = 16'hBABA
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          op_valid_i,
  input  logic [1:0]    op_i,
  input  logic [AW:0]   idx_i,
  input  logic [DW-1:0] wdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          ok_o,
  output logic [DW-1:0] rdata_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          sig_ok_i,
  input  logic [DW-1:0] st_rdata_i,
  output logic          st_we_o,
  output logic          st_clr_o,
  output logic [AW-1:0] st_raddr_o,
  output logic          acc_clr_o,
  output logic          acc_add_o,
  input  logic [DW-1:0] sum_nxt_i
);
  localparam logic [AW-1:0] LAST    = AW'(WORDS - 1);
  localparam logic [AW-1:0] CS_LAST = AW'(WORDS - 2);
  localparam logic [AW:0]   LIMIT   = (AW+1)'(WORDS);

  ee_state_e     state_q;
  logic [AW-1:0] addr_q, idx_q;
  logic [DW-1:0] wdata_q;
  logic          ack, accept, idx_bad, last;
  ee_op_e        op;

  assign op        = ee_op_e'(op_i);
  assign ack       = mem_req_o && mem_ack_i;
  assign accept    = op_valid_i && (state_q == ST_IDLE);
  assign idx_bad   = (idx_i >= LIMIT);
  assign last      = (addr_q == LAST);

  assign busy_o      = (state_q != ST_IDLE);
  assign mem_req_o   = (state_q == ST_FILL) || (state_q == ST_WR) ||
                       (state_q == ST_CS_RD) || (state_q == ST_CS_WR);
  assign mem_we_o    = (state_q == ST_WR) || (state_q == ST_CS_WR);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;

  assign st_raddr_o = (state_q == ST_RESP) ? idx_q : idx_i[AW-1:0];
  assign st_we_o    = (state_q == ST_FILL) && ack;
  assign st_clr_o   = ((state_q == ST_FILL) && ack && last && (sum_nxt_i != SUM_TARGET)) ||
                      (((state_q == ST_WR) || (state_q == ST_CS_WR)) && ack);
  assign acc_clr_o  = accept;
  assign acc_add_o  = ack && ((state_q == ST_FILL) || (state_q == ST_CS_RD));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      idx_q   <= '0;
      wdata_q <= '0;
      done_o  <= 1'b0;
      ok_o    <= 1'b0;
      rdata_o <= '0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        ST_IDLE: if (op_valid_i) begin
          idx_q  <= idx_i[AW-1:0];
          addr_q <= '0;
          case (op)
            OP_LOOKUP: begin
              if (idx_bad) begin
                done_o <= 1'b1; ok_o <= 1'b0; rdata_o <= '0;
              end else if (sig_ok_i) begin
                done_o <= 1'b1; ok_o <= 1'b1; rdata_o <= st_rdata_i;
              end else begin
                state_q <= ST_FILL;
              end
            end
            OP_WRITE: begin
              if (idx_bad) begin
                done_o <= 1'b1; ok_o <= 1'b0; rdata_o <= '0;
              end else begin
                addr_q  <= idx_i[AW-1:0];
                wdata_q <= wdata_i;
                state_q <= ST_WR;
              end
            end
            OP_CSUM: state_q <= ST_CS_RD;
            default: begin
              done_o <= 1'b1; ok_o <= 1'b0; rdata_o <= '0;
            end
          endcase
        end
        ST_FILL: if (ack) begin
          if (last) state_q <= ST_RESP;
          else      addr_q  <= addr_q + 1'b1;
        end
        ST_RESP: begin
          done_o  <= 1'b1;
          ok_o    <= sig_ok_i;
          rdata_o <= sig_ok_i ? st_rdata_i : '0;
          state_q <= ST_IDLE;
        end
        ST_WR: if (ack) begin
          done_o <= 1'b1; ok_o <= 1'b1; rdata_o <= '0;
          state_q <= ST_IDLE;
        end
        ST_CS_RD: if (ack) begin
          if (addr_q == CS_LAST) begin
            wdata_q <= SUM_TARGET - sum_nxt_i;
            addr_q  <= LAST;
            state_q <= ST_CS_WR;
          end else begin
            addr_q <= addr_q + 1'b1;
          end
        end
        ST_CS_WR: if (ack) begin
          done_o <= 1'b1; ok_o <= 1'b1; rdata_o <= wdata_q;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));
  // R2
  fill_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FILL) && ack && !last |=> mem_addr_o == $past(mem_addr_o) + 1'b1);
  // R6
  range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && (op == OP_LOOKUP) && idx_bad |=> done_o && !ok_o && (rdata_o == '0) && !mem_req_o);
  // R3
  hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && (op == OP_LOOKUP) && !idx_bad && sig_ok_i |=> done_o && ok_o && !mem_req_o);
  // R4
  fail_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !ok_o |-> rdata_o == '0);
  // R7
  wr_inval_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && mem_ack_i |=> !sig_ok_i);
  // R9
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(op_valid_i));
endmodule

// File: rtl/ee_shadow_cache.sv
module ee_shadow_cache #(
  parameter int WORDS  = 64,
  parameter int DW     = 16,
  parameter int SIG_HI = 15,
  parameter int SIG_LO = 14,
  parameter logic [SIG_HI-SIG_LO:0] SIG_VALID = 2'b01,
  parameter logic [DW-1:0] SUM_TARGET = 16'hBABA
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     op_valid_i,
  input  logic [1:0]               op_i,
  input  logic [$clog2(WORDS):0]   idx_i,
  input  logic [DW-1:0]            wdata_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     ok_o,
  output logic [DW-1:0]            rdata_o,
  output logic                     mem_req_o,
  output logic                     mem_we_o,
  output logic [$clog2(WORDS)-1:0] mem_addr_o,
  output logic [DW-1:0]            mem_wdata_o,
  input  logic                     mem_ack_i,
  input  logic [DW-1:0]            mem_rdata_i
);
  localparam int AW = $clog2(WORDS);

  logic          sig_ok, st_we, st_clr, acc_clr, acc_add;
  logic [AW-1:0] st_raddr;
  logic [DW-1:0] st_rdata, sum_q, sum_nxt;

  ee_shadow_store #(
    .WORDS(WORDS), .DW(DW), .AW(AW),
    .SIG_HI(SIG_HI), .SIG_LO(SIG_LO), .SIG_VALID(SIG_VALID)
  ) u_store (
    .clk_i, .rst_ni,
    .we_i(st_we), .waddr_i(mem_addr_o), .wdata_i(mem_rdata_i),
    .clr_sig_i(st_clr), .raddr_i(st_raddr),
    .rdata_o(st_rdata), .sig_ok_o(sig_ok)
  );

  ee_sum_acc #(.DW(DW)) u_acc (
    .clk_i, .rst_ni,
    .clr_i(acc_clr), .add_i(acc_add), .din_i(mem_rdata_i),
    .sum_o(sum_q), .sum_nxt_o(sum_nxt)
  );

  ee_shadow_ctrl #(
    .WORDS(WORDS), .DW(DW), .AW(AW), .SUM_TARGET(SUM_TARGET)
  ) u_ctrl (
    .clk_i, .rst_ni,
    .op_valid_i, .op_i, .idx_i, .wdata_i,
    .busy_o, .done_o, .ok_o, .rdata_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ack_i, .mem_rdata_i,
    .sig_ok_i(sig_ok), .st_rdata_i(st_rdata), .st_we_o(st_we), .st_clr_o(st_clr),
    .st_raddr_o(st_raddr), .acc_clr_o(acc_clr), .acc_add_o(acc_add),
    .sum_nxt_i(sum_nxt)
  );

  logic unused_sum;
  assign unused_sum = ^sum_q;
endmodule

// File: tb/ee_shadow_cache_test.sv
module ee_shadow_cache_test;
  localparam int CLK_HALF = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [6:0]  idx = '0;
  logic [15:0] wdata = '0;
  logic        busy, done, ok;
  logic [15:0] rdata;
  logic        mreq, mwe, mack;
  logic [5:0]  maddr;
  logic [15:0] mwdata, mrdata;

  logic [15:0] mem [64];
  logic [15:0] sh [64];
  bit          mv;
  int          rd_cnt = 0, wr_cnt = 0, order_err = 0, last_rd = -1;
  int          vectors = 0, fails = 0;

  always #(CLK_HALF) clk = ~clk;

  ee_shadow_cache uut (
    .clk_i(clk), .rst_ni(rst_n),
    .op_valid_i(op_valid), .op_i(op), .idx_i(idx), .wdata_i(wdata),
    .busy_o(busy), .done_o(done), .ok_o(ok), .rdata_o(rdata),
    .mem_req_o(mreq), .mem_we_o(mwe), .mem_addr_o(maddr), .mem_wdata_o(mwdata),
    .mem_ack_i(mack), .mem_rdata_i(mrdata)
  );

  // device model: one-cycle acknowledge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mack   <= 1'b0;
      mrdata <= '0;
    end else if (mreq && !mack) begin
      mack <= 1'b1;
      if (mwe) begin
        mem[maddr] = mwdata;
        wr_cnt++;
      end else begin
        mrdata <= mem[maddr];
        if (maddr != 0 && int'(maddr) != last_rd + 1) order_err++;
        last_rd = int'(maddr);
        rd_cnt++;
      end
    end else begin
      mack <= 1'b0;
    end
  end

  function automatic logic [15:0] sum_to(int n);
    logic [15:0] s = '0;
    for (int i = 0; i < n; i++) s += mem[i];
    return s;
  endfunction

  function automatic bit image_ok();
    return (sum_to(64) == 16'hBABA) && (mem[0][15:14] == 2'b01);
  endfunction

  task automatic load_image(bit good_sum, logic [1:0] sig);
    for (int i = 0; i < 64; i++) mem[i] = 16'($urandom);
    mem[0][15:14] = sig;
    mem[63] = 16'hBABA - sum_to(63) + (good_sum ? 16'd0 : 16'd1);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    vectors++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, expv);
    end
  endtask

  task automatic run_op(logic [1:0] o, logic [6:0] ix, logic [15:0] wd,
                        output logic r_ok, output logic [15:0] r_data, output int lat);
    @(negedge clk);
    op = o; idx = ix; wdata = wd; op_valid = 1'b1;
    while (busy) @(negedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    lat = 1;
    while (!done && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
    if (!done) begin
      fails++;
      $display("FAIL R9: operation did not complete, got lat %0d expected < 1000", lat);
    end
    r_ok = ok; r_data = rdata;
  endtask

  // model-based op with prediction
  task automatic model_op(logic [1:0] o, logic [6:0] ix, logic [15:0] wd);
    logic r_ok; logic [15:0] r_d; int lat, rd0, wr0;
    logic e_ok; logic [15:0] e_d; int e_rd, e_wr;
    rd0 = rd_cnt; wr0 = wr_cnt;
    e_rd = 0; e_wr = 0; e_ok = 1'b0; e_d = '0;
    case (o)
      2'b00: if (ix < 64) begin
        if (!mv) begin
          e_rd = 64;
          for (int i = 0; i < 64; i++) sh[i] = mem[i];
          mv = image_ok();
        end
        e_ok = mv; e_d = mv ? sh[ix] : 16'h0;
      end
      2'b01: if (ix < 64) begin e_ok = 1'b1; e_wr = 1; mv = 1'b0; end
      2'b10: begin
        e_ok = 1'b1; e_rd = 63; e_wr = 1; e_d = 16'hBABA - sum_to(63); mv = 1'b0;
      end
      default: ;
    endcase
    run_op(o, ix, wd, r_ok, r_d, lat);
    chk(o == 2'b00 ? (ix < 64 ? "R3/R4/R5 ok" : "R6 ok") : (o == 2'b11 ? "R10 ok" : "R7/R8 ok"),
        32'(r_ok), 32'(e_ok));
    chk("R3/R8 data", 32'(r_d), 32'(e_d));
    chk("R2 read count", rd_cnt - rd0, e_rd);
    chk("R7 write count", wr_cnt - wr0, e_wr);
  endtask

  initial begin
    logic r_ok; logic [15:0] r_d; int lat, rd0;
    logic [15:0] exp_cs;
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) mem[i] = '0;
    mv = 1'b0;
    #(CLK_HALF * 5);
    // R1 reset state
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 mem_req", 32'(mreq), 0);
    chk("R1 rdata", 32'(rdata), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R3 refill on first lookup
    load_image(1'b1, 2'b01);
    rd0 = rd_cnt;
    run_op(2'b00, 7'd5, '0, r_ok, r_d, lat);
    chk("R3 first ok", 32'(r_ok), 1);
    chk("R3 first data", 32'(r_d), 32'(mem[5]));
    chk("R2 reads", rd_cnt - rd0, 64);
    chk("R2 order", order_err, 0);
    chk("R9 refill busy", 32'(lat >= 128), 1);
    for (int i = 0; i < 64; i++) sh[i] = mem[i];
    mv = 1'b1;

    // R3 hits: one cycle, no traffic, even with device changed behind
    mem[7] = ~mem[7];
    rd0 = rd_cnt;
    run_op(2'b00, 7'd7, '0, r_ok, r_d, lat);
    chk("R3 hit stale copy", 32'(r_d), 32'(sh[7]));
    chk("R3 hit latency", lat, 1);
    chk("R3 hit no reads", rd_cnt - rd0, 0);
    mem[7] = sh[7];

    // R6 out of range
    run_op(2'b00, 7'd64, '0, r_ok, r_d, lat);
    chk("R6 idx64 ok", 32'(r_ok), 0);
    chk("R6 idx64 latency", lat, 1);
    model_op(2'b00, 7'd127, '0);

    // R10 reserved and bad-index write
    model_op(2'b11, 7'd3, 16'h1234);
    model_op(2'b01, 7'd100, 16'h1234);

    // R7 write invalidates; R4 bad sum then refills again
    model_op(2'b01, 7'd9, 16'h5A5A);
    chk("R7 device word", 32'(mem[9]), 32'h5A5A);
    model_op(2'b00, 7'd9, '0);
    model_op(2'b00, 7'd9, '0);
    // R6 while invalid: no refill
    model_op(2'b00, 7'd70, '0);

    // R8 checksum update, then valid again
    exp_cs = 16'hBABA - sum_to(63);
    model_op(2'b10, '0, '0);
    chk("R8 word63", 32'(mem[63]), 32'(exp_cs));
    model_op(2'b00, 7'd9, '0);
    chk("R8 order", order_err, 0);

    // R5 good sum, wrong signature
    load_image(1'b1, 2'b10);
    model_op(2'b01, 7'd20, mem[20]);
    model_op(2'b00, 7'd1, '0);
    load_image(1'b1, 2'b00);
    model_op(2'b00, 7'd1, '0);

    // random mix
    for (int n = 0; n < 90; n++) begin
      int r;
      r = int'($urandom % 10);
      if (r < 6)       model_op(2'b00, 7'($urandom % 72), '0);
      else if (r < 8)  model_op(2'b01, 7'($urandom % 68), 16'($urandom));
      else if (r == 8) model_op(2'b10, '0, '0);
      else             model_op(2'b11, 7'($urandom % 64), '0);
    end
    chk("R2 order final", order_err, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(CLK_HALF * 2 * 200000);
    fails++;
    $display("FAIL R9: watchdog expired, got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule